// File: doc/BRIEF.md
# Floppy Drive and Motor Output Decoder

This block holds the 8-bit drive-control register of a floppy disk controller and turns it into the active-low drive-select and motor-on lines for up to four drives. The host writes the register through an 8-bit write port and can read it back at any time. The block also provides a held soft-reset level for the controller core, and two enables that let the DMA request and interrupt outputs drive.

Three configuration inputs shape the decode. The host mode input selects AT, PS/2 or Model 30 behaviour. The swap input exchanges physical drives 0 and 1. The decode-mode input chooses between direct decode of four drives and an encoded form that feeds an external two-to-four decoder. All outputs are registered. Each output updates on the clock edge that samples a write or a configuration change.

Top module: `fdd_dor_top`

## Requirements
- R1: While reset is asserted, and after it is released with no write, the register reads 00h, every `sel_n` and `mtr_n` line is high, `core_rst` is 1, and in AT mode both enables are 0.
- R2: `rd_data` returns the value of the most recent write. Without `wr_en` the register and `rd_data` keep their value.
- R3: Bit 2 of the register is an active-low soft reset. `core_rst` is 1 while that bit is 0 and 0 while it is 1. Writing it has no effect on the other register bits.
- R4: In direct decode (`ext_decode`=0), bits 1:0 give a drive number n. `sel_n[n]` is low only when motor bit 4+n is set. All other select lines are high, and all of them are high when the motor bit of the chosen drive is clear.
- R5: In direct decode, `mtr_n[k]` is the inverse of register bit 4+k.
- R6: With `swap_en`=1 in direct decode, drive number 0 drives `sel_n[1]` and number 1 drives `sel_n[0]`. Each is still gated by its own motor bit. `mtr_n[0]` becomes the inverse of bit 5 and `mtr_n[1]` the inverse of bit 4. Lines 2 and 3 are unchanged.
- R7: In external decode (`ext_decode`=1), `sel_n[1:0]` carry the 2-bit drive code in true polarity, with `sel_n[0]` as the low bit. `mtr_n[0]` is low when motor bit 4+n of the chosen drive number n is set. `sel_n[3:2]` and `mtr_n[3:1]` stay high.
- R8: In external decode with `swap_en`=1, drive numbers 0 and 1 present the codes 01 and 00 respectively. Numbers 2 and 3 keep their own codes.
- R9: When `host_mode` is not 01 (00 is AT, 10 is Model 30, 11 is treated as AT), `dma_io_en` and `irq_drv_en` both follow register bit 3.
- R10: When `host_mode` is 01 (PS/2), `dma_io_en` and `irq_drv_en` are 1 whatever bit 3 holds.
- R11: Every output changes on the first rising clock edge after `wr_en` or a configuration input is applied, and not before that edge.
- R12: In direct decode without swap, the values 1Ch, 2Dh, 4Eh and 8Fh each assert exactly the select line and motor line of drive 0, 1, 2 and 3 respectively, and also release the soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset, released synchronously inside the block |
| wr_en | input | 1 | Host write strobe, sampled on the rising edge |
| wr_data | input | 8 | Host write data |
| host_mode | input | 2 | 00 AT, 01 PS/2, 10 Model 30, 11 treated as AT |
| swap_en | input | 1 | Exchange physical drives 0 and 1 |
| ext_decode | input | 1 | 0 selects direct four-drive decode, 1 selects encoded output for an external decoder |
| rd_data | output | 8 | Register read-back |
| sel_n | output | 4 | Active-low drive selects |
| mtr_n | output | 4 | Active-low motor-on lines |
| core_rst | output | 1 | Held soft-reset level for the controller core, active high |
| dma_io_en | output | 1 | Enables the DMA request output and the acknowledge and terminal-count inputs |
| irq_drv_en | output | 1 | Enables the interrupt output driver |

## Verification
Every result of this block is due exactly one rising edge after its cause. This applies to a write, a mode change, a swap change and a decode-mode change alike. The bench changes inputs on the falling edge and compares all outputs on the next falling edge, half a period after the edge that loaded them. For R11 it also samples just before that edge and expects the previous values still to be present. After reset is released, the bench waits out the internal two-stage release before it issues the first write.

// File: rtl/fdd_dor_pkg.sv
package fdd_dor_pkg;
  localparam int DATA_W  = 8;
  localparam int NUM_DRV = 4;
  localparam int DRV_W   = $clog2(NUM_DRV);
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    HM_AT  = 2'b00,
    HM_PS2 = 2'b01,
    HM_M30 = 2'b10,
    HM_RSV = 2'b11
  } host_mode_e;

  // Field order is fixed by the host's register layout.
  typedef struct packed {
    logic [NUM_DRV-1:0] motor;
    logic               dma_gate;
    logic               run_n_rst;
    logic [DRV_W-1:0]   drv;
  } dor_t;
endpackage

// File: rtl/fdd_dor_rst_sync.sv
module fdd_dor_rst_sync #(
  parameter int STAGES = fdd_dor_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fdd_dor_reg.sv
module fdd_dor_reg
  import fdd_dor_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output dor_t              dor_q,
  output dor_t              dor_d
);
  always_comb begin
    dor_d = dor_q;
    if (wr_en) dor_d = dor_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dor_q <= '0;
    else if (wr_en) dor_q <= dor_d;
  end
endmodule

// File: rtl/fdd_dor_decode.sv
module fdd_dor_decode
  import fdd_dor_pkg::*;
(
  input  dor_t               dor,
  input  logic               swap_en,
  input  logic               ext_decode,
  output logic [NUM_DRV-1:0] sel_n,
  output logic [NUM_DRV-1:0] mtr_n
);
  logic [NUM_DRV-1:0] log_sel;
  logic [NUM_DRV-1:0] phy_sel;
  logic [NUM_DRV-1:0] phy_mtr;
  logic [DRV_W-1:0]   ext_code;

  // Logical select: chosen drive, gated by its own motor bit.
  genvar gi;
  generate
    for (gi = 0; gi < NUM_DRV; gi++) begin : g_lsel
      assign log_sel[gi] = (dor.drv == DRV_W'(gi)) && dor.motor[gi];
    end
  endgenerate

  // Swap is a permutation of drives 0 and 1, applied to selects and motors alike.
  always_comb begin
    for (int p = 0; p < NUM_DRV; p++) begin
      if (swap_en && p < 2) begin
        phy_sel[p] = log_sel[p ^ 1];
        phy_mtr[p] = dor.motor[p ^ 1];
      end else begin
        phy_sel[p] = log_sel[p];
        phy_mtr[p] = dor.motor[p];
      end
    end
  end

  always_comb begin
    ext_code = dor.drv;
    if (swap_en && !dor.drv[DRV_W-1]) ext_code[0] = ~dor.drv[0];
  end

  always_comb begin
    if (ext_decode) begin
      sel_n = '1;
      sel_n[DRV_W-1:0] = ext_code;
      mtr_n = '1;
      mtr_n[0] = ~dor.motor[dor.drv];
    end else begin
      sel_n = ~phy_sel;
      mtr_n = ~phy_mtr;
    end
  end
endmodule

// File: rtl/fdd_dor_gate.sv
module fdd_dor_gate
  import fdd_dor_pkg::*;
(
  input  logic [1:0] host_mode,
  input  logic       dma_gate,
  output logic       dma_en,
  output logic       irq_en
);
  always_comb begin
    if (host_mode_e'(host_mode) == HM_PS2) begin
      dma_en = 1'b1;
      irq_en = 1'b1;
    end else begin
      dma_en = dma_gate;
      irq_en = dma_gate;
    end
  end
endmodule

// File: rtl/fdd_dor_top.sv
module fdd_dor_top
  import fdd_dor_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [1:0]         host_mode,
  input  logic               swap_en,
  input  logic               ext_decode,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_DRV-1:0] sel_n,
  output logic [NUM_DRV-1:0] mtr_n,
  output logic               core_rst,
  output logic               dma_io_en,
  output logic               irq_drv_en
);
  logic               rst_q_n;
  dor_t               dor_q;
  dor_t               dor_d;
  logic [NUM_DRV-1:0] sel_n_d;
  logic [NUM_DRV-1:0] mtr_n_d;
  logic               dma_d;
  logic               irq_d;

  fdd_dor_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  fdd_dor_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .dor_q   (dor_q),
    .dor_d   (dor_d)
  );

  // Decode works on the next register value so the pins settle with the register.
  fdd_dor_decode u_dec (
    .dor        (dor_d),
    .swap_en    (swap_en),
    .ext_decode (ext_decode),
    .sel_n      (sel_n_d),
    .mtr_n      (mtr_n_d)
  );

  fdd_dor_gate u_gate (
    .host_mode (host_mode),
    .dma_gate  (dor_d.dma_gate),
    .dma_en    (dma_d),
    .irq_en    (irq_d)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sel_n      <= '1;
      mtr_n      <= '1;
      core_rst   <= 1'b1;
      dma_io_en  <= 1'b0;
      irq_drv_en <= 1'b0;
    end else begin
      sel_n      <= sel_n_d;
      mtr_n      <= mtr_n_d;
      core_rst   <= ~dor_d.run_n_rst;
      dma_io_en  <= dma_d;
      irq_drv_en <= irq_d;
    end
  end

  assign rd_data = dor_q;
endmodule

// File: rtl/fdd_dor_chk.sv
module fdd_dor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [1:0] host_mode,
  input logic       ext_decode,
  input logic [7:0] rd_data,
  input logic [3:0] sel_n,
  input logic [3:0] mtr_n,
  input logic       core_rst,
  input logic       dma_io_en,
  input logic       irq_drv_en
);
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  assert_soft_reset_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst == ~rd_data[2]);

  assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_decode |=> $countones(~sel_n) <= 1);

  assert_select_has_motor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_decode |=> ((~sel_n) & mtr_n) == 4'b0000);

  assert_ext_upper_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_decode |=> (sel_n[3:2] == 2'b11) && (mtr_n[3:1] == 3'b111));

  assert_ps2_enables_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_mode == 2'b01 |=> dma_io_en && irq_drv_en);

  assert_at_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_mode != 2'b01 |=> dma_io_en == rd_data[3]);
endmodule

bind fdd_dor_top fdd_dor_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .host_mode  (host_mode),
  .ext_decode (ext_decode),
  .rd_data    (rd_data),
  .sel_n      (sel_n),
  .mtr_n      (mtr_n),
  .core_rst   (core_rst),
  .dma_io_en  (dma_io_en),
  .irq_drv_en (irq_drv_en)
);

// File: tb/fdd_dor_top_bench.sv
module fdd_dor_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [1:0] host_mode;
  logic       swap_en;
  logic       ext_decode;
  logic [7:0] rd_data;
  logic [3:0] sel_n;
  logic [3:0] mtr_n;
  logic       core_rst;
  logic       dma_io_en;
  logic       irq_drv_en;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] model;

  always #5 clk = ~clk;

  fdd_dor_top u_fdd_dor_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .host_mode(host_mode), .swap_en(swap_en), .ext_decode(ext_decode),
    .rd_data(rd_data), .sel_n(sel_n), .mtr_n(mtr_n), .core_rst(core_rst),
    .dma_io_en(dma_io_en), .irq_drv_en(irq_drv_en)
  );

  function automatic logic [3:0] exp_sel(input logic [7:0] r, input logic sw, input logic ex);
    logic [3:0] v;
    logic [1:0] code;
    if (ex) begin
      code = r[1:0];
      if (sw && code == 2'd0) code = 2'd1;
      else if (sw && code == 2'd1) code = 2'd0;
      v = {2'b11, code};
    end else begin
      for (int p = 0; p < 4; p++) begin
        int l;
        l = (sw && p < 2) ? (p ^ 1) : p;
        v[p] = !((int'(r[1:0]) == l) && r[4+l]);
      end
    end
    return v;
  endfunction

  function automatic logic [3:0] exp_mtr(input logic [7:0] r, input logic sw, input logic ex);
    logic [3:0] v;
    if (ex) begin
      v = 4'b1111;
      v[0] = !r[4 + int'(r[1:0])];
    end else begin
      for (int p = 0; p < 4; p++) begin
        int l;
        l = (sw && p < 2) ? (p ^ 1) : p;
        v[p] = !r[4+l];
      end
    end
    return v;
  endfunction

  function automatic logic exp_en(input logic [7:0] r, input logic [1:0] m);
    return (m == 2'b01) ? 1'b1 : r[3];
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare every output against the model; tags follow the active decode form.
  task automatic check_all(input string ctx);
    string st;
    string et;
    st = ext_decode ? (swap_en ? "R8" : "R7") : (swap_en ? "R6" : "R4");
    et = (host_mode == 2'b01) ? "R10" : "R9";
    chk({ctx, " rd R2"}, rd_data, model);
    chk({ctx, " sel ", st}, {4'h0, sel_n}, {4'h0, exp_sel(model, swap_en, ext_decode)});
    chk({ctx, " mtr ", ext_decode ? "R7" : (swap_en ? "R6" : "R5")},
        {4'h0, mtr_n}, {4'h0, exp_mtr(model, swap_en, ext_decode)});
    chk({ctx, " core_rst R3"}, {7'h0, core_rst}, {7'h0, ~model[2]});
    chk({ctx, " dma ", et}, {7'h0, dma_io_en}, {7'h0, exp_en(model, host_mode)});
    chk({ctx, " irq ", et}, {7'h0, irq_drv_en}, {7'h0, exp_en(model, host_mode)});
  endtask

  // Drive at a falling edge, compare at the next falling edge (one rising edge later).
  task automatic step(input logic we, input logic [7:0] d, input logic [1:0] m,
                      input logic sw, input logic ex, input string ctx);
    wr_en = we; wr_data = d; host_mode = m; swap_en = sw; ext_decode = ex;
    if (we) model = d;
    @(negedge clk);
    wr_en = 1'b0;
    check_all(ctx);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] old_sel;
    void'($urandom(32'd1234));
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    host_mode = 2'b00; swap_en = 1'b0; ext_decode = 1'b0;
    model = 8'h00;
    repeat (3) @(negedge clk);
    check_all("reset R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("after release R1");

    // R12 activation values
    step(1, 8'h1C, 2'b00, 0, 0, "drv0 R12");
    chk("drv0 sel R12", {4'h0, sel_n}, 8'h0E);
    step(1, 8'h2D, 2'b00, 0, 0, "drv1 R12");
    chk("drv1 sel R12", {4'h0, sel_n}, 8'h0D);
    step(1, 8'h4E, 2'b00, 0, 0, "drv2 R12");
    chk("drv2 sel R12", {4'h0, sel_n}, 8'h0B);
    step(1, 8'h8F, 2'b00, 0, 0, "drv3 R12");
    chk("drv3 sel R12", {4'h0, sel_n}, 8'h07);
    chk("drv3 mtr R12", {4'h0, mtr_n}, 8'h07);

    // R4: drive chosen but its motor off -> no select
    step(1, 8'h2C, 2'b00, 0, 0, "motor off R4");
    chk("motor off sel R4", {4'h0, sel_n}, 8'h0F);
    // R6: swap in direct decode
    step(1, 8'h1C, 2'b00, 1, 0, "swap R6");
    chk("swap sel R6", {4'h0, sel_n}, 8'h0D);
    chk("swap mtr R6", {4'h0, mtr_n}, 8'h0D);
    // R7 / R8: external decode
    step(1, 8'h2D, 2'b00, 0, 1, "ext R7");
    chk("ext sel R7", {4'h0, sel_n}, 8'h0D);
    chk("ext mtr R7", {4'h0, mtr_n}, 8'h0E);
    step(0, 8'h00, 2'b00, 1, 1, "ext swap R8");
    chk("ext swap sel R8", {4'h0, sel_n}, 8'h0C);
    // R3: soft reset held, other bits intact
    step(1, 8'h10, 2'b00, 0, 0, "soft rst R3");
    chk("soft rst level R3", {7'h0, core_rst}, 8'h01);
    chk("soft rst mtr R3", {4'h0, mtr_n}, 8'h0E);
    // R9 / R10 gating
    step(1, 8'h14, 2'b00, 0, 0, "AT gate off R9");
    chk("AT dma off R9", {7'h0, dma_io_en}, 8'h00);
    step(0, 8'h00, 2'b01, 0, 0, "PS2 R10");
    chk("PS2 dma on R10", {7'h0, dma_io_en}, 8'h01);
    step(1, 8'h08, 2'b10, 0, 0, "M30 gate on R9");
    chk("M30 irq on R9", {7'h0, irq_drv_en}, 8'h01);

    // R11: nothing moves before the capturing edge
    wr_en = 1'b1; wr_data = 8'h8F; host_mode = 2'b00; swap_en = 1'b0; ext_decode = 1'b0;
    old_sel = sel_n;
    #4;
    chk("pre-edge rd R11", rd_data, 8'h08);
    chk("pre-edge sel R11", {4'h0, sel_n}, {4'h0, old_sel});
    model = 8'h8F;
    @(negedge clk);
    wr_en = 1'b0;
    check_all("post-edge R11");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      step(1'($urandom % 2), 8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), "rand");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule